// File: doc/BRIEF.md
# Reset Sequencer with Cause Detection

This block produces the internal reset of a small controller and decides which event caused it. It watches four things: a power-on pulse, the shared active-low reset pin, a request from the clock monitor and a timeout request from the watchdog. It releases the core only after the reset has been serviced. At that moment it presents the 16-bit address of the reset handler the core should fetch first. All timing is counted in bus clock cycles.

After power-on, the core is held in reset long enough for the oscillator to settle. A low level on the pin held by something outside counts as a reset once it has lasted longer than two cycles. Service of that reset waits until the pin is high again and adds no settling delay.

Resets raised inside the block pull the pin low for a fixed time and then let it go. After a further fixed wait the block reads the pin again. If the pin is still low, an outside agent is also holding reset, and the cause is reported as external. If the pin is high, the block reports the clock-monitor handler when a clock-monitor request was recorded, and the watchdog handler otherwise.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high and for 8192 cycles after it falls, `core_rst_o` is 1. The vector strobe then reports 16'hFFFE, provided the pin is high.
- R2: In normal operation, a pin low for three or more consecutive clock edges puts the core into reset. A low lasting two edges or fewer has no effect on `core_rst_o`.
- R3: An external reset is held until the pin returns high. The strobe with 16'hFFFE comes at the first clock edge that sees the pin high, with no added settling delay.
- R4: A clock-monitor or watchdog request in normal operation sets `rst_pin_pull_o` for exactly 64 cycles, starting with the next edge. `core_rst_o` is 1 throughout.
- R5: The pin is read 32 cycles after the pull is released. If it is low, the block waits for it to go high and then reports 16'hFFFE.
- R6: If the pin is high at that read, the reported vector is 16'hFFFC when a clock-monitor request was recorded since the last strobe, and 16'hFFFA otherwise.
- R7: The recorded cause is cleared when a vector is presented, so a later watchdog-only reset reports 16'hFFFA.
- R8: A new request while the pin is being pulled restarts the 64-cycle pull count from that edge.
- R9: `vec_valid_o` is a one-cycle pulse at the edge where `core_rst_o` falls. `rst_vec_o` changes only with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_i | input | 1 | Power-on pulse, active high, synchronous |
| rst_pin_n_i | input | 1 | Level seen on the shared reset pin (0 = reset) |
| clkmon_fail_i | input | 1 | Clock-monitor reset request |
| wdog_timeout_i | input | 1 | Watchdog timeout request |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| rst_pin_pull_o | output | 1 | Open-drain enable: 1 pulls the pin low |
| rst_vec_o | output | 16 | Handler address for the recognised cause |
| vec_valid_o | output | 1 | One-cycle strobe marking a new vector |

## Verification
For every stimulus the bench computes the exact cycle in which the vector strobe is due:
- 8192 edges after power-on is released;
- 97 edges after the request is driven for an internal reset (one edge to register the request, 64 cycles of pull, 32 cycles of wait);
- one edge after the pin is released for an external reset.

The driver queues the expected vector together with that cycle number. The monitor compares both when the strobe appears, so a strobe that comes early, late or unexpected is reported.

The pull output and the internal reset are also checked at the last cycle before each edge where they should change and at the first cycle after it. This includes the shifted release when a pull is restarted and a pin released exactly one cycle before the read.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_POR,
    ST_RUN,
    ST_DRIVE,
    ST_SAMPLE,
    ST_EXTWAIT
  } seq_state_t;

  localparam logic [15:0] VEC_PIN    = 16'hFFFE;
  localparam logic [15:0] VEC_CLKMON = 16'hFFFC;
  localparam logic [15:0] VEC_WDOG   = 16'hFFFA;
endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             term
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign term = (cnt == limit - 1'b1);
endmodule

// File: rtl/rstseq_lowfilt.sv
module rstseq_lowfilt #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pin_n,
  output logic det
);
  localparam int FLT_W = $clog2(MIN_LOW + 1);
  localparam logic [FLT_W-1:0] LAST = FLT_W'(MIN_LOW - 1);

  logic [FLT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || pin_n) low_cnt <= '0;
    else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
  end

  assign det = arm && !pin_n && (low_cnt == LAST);
endmodule

// File: rtl/rstseq_vecsel.sv
module rstseq_vecsel
  import rstseq_pkg::*;
(
  input  logic        internal_cause,
  input  logic        clkmon_seen,
  output logic [15:0] vec
);
  always_comb begin
    if (!internal_cause)  vec = VEC_PIN;
    else if (clkmon_seen) vec = VEC_CLKMON;
    else                  vec = VEC_WDOG;
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int POR_CYCLES   = 8192,
  parameter int PULL_CYCLES  = 64,
  parameter int SAMPLE_DELAY = 32,
  parameter int LOW_IGNORED  = 2
) (
  input  logic        clk,
  input  logic        por_i,
  input  logic        rst_pin_n_i,
  input  logic        clkmon_fail_i,
  input  logic        wdog_timeout_i,
  output logic        core_rst_o,
  output logic        rst_pin_pull_o,
  output logic [15:0] rst_vec_o,
  output logic        vec_valid_o
);
  localparam int MAX_AB  = (POR_CYCLES > PULL_CYCLES) ? POR_CYCLES : PULL_CYCLES;
  localparam int MAX_CNT = (MAX_AB > SAMPLE_DELAY) ? MAX_AB : SAMPLE_DELAY;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int MIN_LOW = LOW_IGNORED + 1;
  localparam logic [CNT_W-1:0] LIM_POR    = CNT_W'(POR_CYCLES);
  localparam logic [CNT_W-1:0] LIM_PULL   = CNT_W'(PULL_CYCLES);
  localparam logic [CNT_W-1:0] LIM_SAMPLE = CNT_W'(SAMPLE_DELAY);

  seq_state_t       state, nstate;
  logic             req, restart, present, internal_cause;
  logic             timer_clr, term, ext_det, clkmon_seen;
  logic [CNT_W-1:0] limit;
  logic [15:0]      sel_vec;

  assign req = clkmon_fail_i | wdog_timeout_i;

  always_comb begin
    case (state)
      ST_POR:   limit = LIM_POR;
      ST_DRIVE: limit = LIM_PULL;
      default:  limit = LIM_SAMPLE;
    endcase
  end

  always_comb begin
    nstate         = state;
    restart        = 1'b0;
    present        = 1'b0;
    internal_cause = 1'b0;
    case (state)
      ST_POR: if (term) begin
        if (rst_pin_n_i) begin nstate = ST_RUN; present = 1'b1; end
        else nstate = ST_EXTWAIT;
      end
      ST_RUN: begin
        if (req)          nstate = ST_DRIVE;
        else if (ext_det) nstate = ST_EXTWAIT;
      end
      ST_DRIVE: begin
        if (req)       restart = 1'b1;
        else if (term) nstate  = ST_SAMPLE;
      end
      ST_SAMPLE: if (term) begin
        if (rst_pin_n_i) begin
          nstate = ST_RUN; present = 1'b1; internal_cause = 1'b1;
        end else nstate = ST_EXTWAIT;
      end
      ST_EXTWAIT: if (rst_pin_n_i) begin nstate = ST_RUN; present = 1'b1; end
      default: nstate = ST_POR;
    endcase
  end

  assign timer_clr = por_i | restart | (nstate != state);

  rstseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .clr   (timer_clr),
    .limit (limit),
    .term  (term)
  );

  rstseq_lowfilt #(.MIN_LOW(MIN_LOW)) i_lowfilt (
    .clk   (clk),
    .rst   (por_i),
    .arm   (state == ST_RUN),
    .pin_n (rst_pin_n_i),
    .det   (ext_det)
  );

  rstseq_vecsel i_vecsel (
    .internal_cause (internal_cause),
    .clkmon_seen    (clkmon_seen),
    .vec            (sel_vec)
  );

  always_ff @(posedge clk) begin
    if (por_i) begin
      state          <= ST_POR;
      core_rst_o     <= 1'b1;
      rst_pin_pull_o <= 1'b0;
      rst_vec_o      <= VEC_PIN;
      vec_valid_o    <= 1'b0;
      clkmon_seen    <= 1'b0;
    end else begin
      state          <= nstate;
      core_rst_o     <= (nstate != ST_RUN);
      rst_pin_pull_o <= (nstate == ST_DRIVE);
      vec_valid_o    <= present;
      if (present) rst_vec_o <= sel_vec;
      if (present) clkmon_seen <= 1'b0;
      else if ((state == ST_RUN || state == ST_DRIVE) && clkmon_fail_i)
        clkmon_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic        clk,
  input logic        por_i,
  input logic        core_rst_o,
  input logic        rst_pin_pull_o,
  input logic [15:0] rst_vec_o,
  input logic        vec_valid_o
);
  // R4: the pin is only pulled while the core is held in reset
  assert_pull_in_reset_R4: assert property (@(posedge clk) disable iff (por_i)
    rst_pin_pull_o |-> core_rst_o);

  // R9: the strobe lasts a single cycle
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (por_i)
    vec_valid_o |=> !vec_valid_o);

  // R9: the core leaves reset only together with a strobe
  assert_release_strobe_R9: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> vec_valid_o);

  // R9: the strobe never comes while the core is still in reset
  assert_strobe_released_R9: assert property (@(posedge clk) disable iff (por_i)
    vec_valid_o |-> !core_rst_o);

  // R9: the vector only changes along with the strobe
  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (por_i)
    !$stable(rst_vec_o) |-> vec_valid_o);

  // R6: only the three handler addresses are ever reported
  assert_vec_legal_R6: assert property (@(posedge clk) disable iff (por_i)
    vec_valid_o |-> (rst_vec_o == 16'hFFFE || rst_vec_o == 16'hFFFC ||
                     rst_vec_o == 16'hFFFA));
endmodule

bind rstseq_top rstseq_chk i_rstseq_chk (
  .clk            (clk),
  .por_i          (por_i),
  .core_rst_o     (core_rst_o),
  .rst_pin_pull_o (rst_pin_pull_o),
  .rst_vec_o      (rst_vec_o),
  .vec_valid_o    (vec_valid_o)
);

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct {
    logic [15:0] vec;
    int          cyc;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ext_low = 1'b0;
  logic cm = 1'b0;
  logic wd = 1'b0;
  logic pin_n;
  logic core_rst, pull, vvalid;
  logic [15:0] vec;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t expq[$];

  assign pin_n = ~(pull | ext_low);

  rstseq_top i_rstseq_top (
    .clk            (clk),
    .por_i          (por),
    .rst_pin_n_i    (pin_n),
    .clkmon_fail_i  (cm),
    .wdog_timeout_i (wd),
    .core_rst_o     (core_rst),
    .rst_pin_pull_o (pull),
    .rst_vec_o      (vec),
    .vec_valid_o    (vvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic expect_vec(input logic [15:0] v, input int at, input string tag);
    exp_t e;
    e.vec = v; e.cyc = at; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic pulse_req(input bit use_cm);
    if (use_cm) cm = 1'b1; else wd = 1'b1;
    @(negedge clk);
    cm = 1'b0; wd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: every strobe is compared against the queued expectation
  always @(negedge clk) begin
    if (!por && vvalid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", vec, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(vec == e.vec, {e.tag, " vector"}, vec, e.vec);
        chk(cyc == e.cyc, {e.tag, " strobe cycle"}, cyc, e.cyc);
        chk(core_rst == 1'b0, "R9 reset released with strobe", core_rst, 0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, WATCHDOG_CYCLES);
    finish_run();
  end

  initial begin
    int c0;
    int c1;
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b1, "R1 reset state core_rst", core_rst, 1);
    chk(pull == 1'b0, "R1 reset state pull", pull, 0);
    chk(vvalid == 1'b0, "R1 reset state strobe", vvalid, 0);

    // R1: power-on stretch
    por = 1'b0; c0 = cyc;
    expect_vec(16'hFFFE, c0 + 8192, "R1");
    wait_until(c0 + 8191);
    chk(core_rst == 1'b1, "R1 held before 8192", core_rst, 1);
    wait_until(c0 + 8192);
    chk(core_rst == 1'b0, "R1 released at 8192", core_rst, 0);
    repeat (4) @(negedge clk);

    // R2: two-cycle low is ignored
    ext_low = 1'b1;
    repeat (2) @(negedge clk);
    ext_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b0, "R2 short low ignored", core_rst, 0);

    // R2/R3: three-cycle low is an external reset
    ext_low = 1'b1; c0 = cyc;
    wait_until(c0 + 2);
    chk(core_rst == 1'b0, "R2 not yet after two", core_rst, 0);
    wait_until(c0 + 3);
    chk(core_rst == 1'b1, "R2 external detected", core_rst, 1);
    wait_until(c0 + 40);
    chk(core_rst == 1'b1, "R3 held while pin low", core_rst, 1);
    c1 = cyc;
    expect_vec(16'hFFFE, c1 + 1, "R3");
    ext_low = 1'b0;
    repeat (4) @(negedge clk);

    // R4/R6: watchdog reset
    c0 = cyc;
    expect_vec(16'hFFFA, c0 + 97, "R6 watchdog");
    pulse_req(1'b0);
    chk(pull == 1'b1 && core_rst == 1'b1, "R4 pull starts", pull, 1);
    wait_until(c0 + 64);
    chk(pull == 1'b1, "R4 pull at 64th cycle", pull, 1);
    wait_until(c0 + 65);
    chk(pull == 1'b0, "R4 pull released", pull, 0);
    chk(core_rst == 1'b1, "R5 reset during wait", core_rst, 1);
    wait_until(c0 + 100);

    // R6: clock monitor reset
    c0 = cyc;
    expect_vec(16'hFFFC, c0 + 97, "R6 clock monitor");
    pulse_req(1'b1);
    wait_until(c0 + 100);

    // R7: cause cleared, watchdog again
    c0 = cyc;
    expect_vec(16'hFFFA, c0 + 97, "R7 cause cleared");
    pulse_req(1'b0);
    wait_until(c0 + 100);

    // R5: pin still low at the read
    c0 = cyc;
    pulse_req(1'b0);
    wait_until(c0 + 70);
    ext_low = 1'b1;
    wait_until(c0 + 98);
    chk(core_rst == 1'b1, "R5 held after low read", core_rst, 1);
    wait_until(c0 + 120);
    c1 = cyc;
    expect_vec(16'hFFFE, c1 + 1, "R5 external at read");
    ext_low = 1'b0;
    repeat (4) @(negedge clk);

    // R5: pin released one cycle before the read
    c0 = cyc;
    expect_vec(16'hFFFA, c0 + 97, "R5 high at read");
    pulse_req(1'b0);
    wait_until(c0 + 70);
    ext_low = 1'b1;
    wait_until(c0 + 96);
    ext_low = 1'b0;
    wait_until(c0 + 100);

    // R8: restart of the pull count
    c0 = cyc;
    expect_vec(16'hFFFC, c0 + 107, "R8 restart");
    pulse_req(1'b0);
    wait_until(c0 + 10);
    pulse_req(1'b1);
    wait_until(c0 + 74);
    chk(pull == 1'b1, "R8 pull extended", pull, 1);
    wait_until(c0 + 75);
    chk(pull == 1'b0, "R8 pull released late", pull, 0);
    wait_until(c0 + 112);

    chk(expq.size() == 0, "R9 all strobes seen", expq.size(), 0);
    finish_run();
  end
endmodule